// File: doc/BRIEF.md
# Exception Entry Controller

This block sits next to a simple in-order core and decides which pending exception to enter and what the core must do to enter it. Each cycle it samples seven request sources: a reset request, an undefined instruction, a software interrupt, a prefetch abort, a data abort, a normal interrupt (IRQ) and a fast interrupt (FIQ). It also samples the current status word and the address of the instruction in execute. It picks one request by fixed priority. One clock later it pulses a take strobe together with the handler address, the new mode, the new status word, the value to save as the saved status, and the link value for the return register.

The vector table sits at base zero, or at a high base when the relocation input is set. Interrupts are level-sensitive and are gated by the disable bits of the current status word. A fast interrupt may preempt a normal-interrupt handler, but a normal interrupt never preempts a fast one. A prefetch fault counts only when the faulting instruction actually reaches execution. When the asynchronous reset is released, the block enters the reset exception on its own. The outputs hold their last values between entries.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_ni is low, take_o and all data outputs are zero. The first take after release is a reset entry: vector at the base, mode 5'h13, status 32'h0000_00D3 and link 0. The first take_o comes one clock after release.
- R2: The entry mode is 5'h13 for reset and software interrupt, 5'h17 for either abort, 5'h1B for undefined instruction, 5'h12 for IRQ and 5'h11 for FIQ.
- R3: The vector is the base plus an offset. The offsets are 0x0 reset, 0x4 undefined, 0x8 software interrupt, 0xC prefetch abort, 0x10 data abort, 0x18 IRQ and 0x1C FIQ. The base is 0 when hivec_i is 0 and 32'hFFFF_0000 when it is 1.
- R4: For non-reset entries, status_o is the sampled status_i with bits 4:0 replaced by the mode and bit 7 (IRQ disable) set. Bit 6 (FIQ disable) is also set on FIQ entry. All other bits are kept. spsr_o always equals the sampled status_i.
- R5: link_o is pc_i+8 for a data abort, 0 for reset, and pc_i+4 for every other exception.
- R6: With several requests pending, the order from highest is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R7: irq_i is ignored when status_i bit 7 is 1 or status_i[4:0] is 5'h11. fiq_i is ignored when status_i bit 6 is 1. FIQ is taken while in IRQ mode (5'h12).
- R8: pabt_req_i is ignored unless pabt_exec_i is 1 in the same cycle.
- R9: take_o rises in the cycle after a qualifying request is sampled and lasts one cycle per entry. The data outputs change only with take_o.
- R10: While take_o is 1, every request except rst_req_i is ignored. A reset request in that cycle is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset exception request |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| pabt_req_i | input | 1 | Instruction fetch fault flag |
| pabt_exec_i | input | 1 | Faulting instruction is being executed |
| dabt_req_i | input | 1 | Data access fault request |
| irq_i | input | 1 | Normal interrupt, level |
| fiq_i | input | 1 | Fast interrupt, level |
| hivec_i | input | 1 | Select high vector base |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Address of instruction in execute |
| take_o | output | 1 | Exception entry strobe |
| vector_o | output | 32 | Handler address |
| mode_o | output | 5 | New mode field |
| status_o | output | 32 | New status word |
| spsr_o | output | 32 | Status word to save |
| link_o | output | 32 | Return register value |

## Verification
The gating assertions assume that status_i and the request inputs are stable across each sampling edge. They also assume that status_i carries a legal mode in bits 4:0. The pulse and hold properties assume that the core does not hold a reset request high for back-to-back cycles. The bench changes every input on the falling edge and returns all requests to zero after each vector. It uses only the seven legal mode encodings and asserts the reset request for one cycle at a time.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  // value is the priority index, 0 highest
  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_DABT = 3'd1,
    EXC_FIQ  = 3'd2,
    EXC_IRQ  = 3'd3,
    EXC_PABT = 3'd4,
    EXC_UND  = 3'd5,
    EXC_SWI  = 3'd6
  } exc_e;

  localparam int NUM_EXC     = 7;
  localparam int IRQ_DIS_BIT = 7;
  localparam int FIQ_DIS_BIT = 6;
  localparam int MODE_W      = 5;
  localparam int VOFF_W      = 5;
  localparam int LOFF_W      = 4;

  typedef struct packed {
    mode_e             mode;
    logic [VOFF_W-1:0] vec_off;
    logic              set_fdis;
    logic [LOFF_W-1:0] link_off;
  } exc_attr_t;

  function automatic exc_attr_t exc_attr(exc_e e);
    exc_attr_t a;
    a = '{mode: MODE_SVC, vec_off: 5'h00, set_fdis: 1'b1, link_off: 4'd0};
    unique case (e)
      EXC_RST:  a = '{mode: MODE_SVC, vec_off: 5'h00, set_fdis: 1'b1, link_off: 4'd0};
      EXC_UND:  a = '{mode: MODE_UND, vec_off: 5'h04, set_fdis: 1'b0, link_off: 4'd4};
      EXC_SWI:  a = '{mode: MODE_SVC, vec_off: 5'h08, set_fdis: 1'b0, link_off: 4'd4};
      EXC_PABT: a = '{mode: MODE_ABT, vec_off: 5'h0C, set_fdis: 1'b0, link_off: 4'd4};
      EXC_DABT: a = '{mode: MODE_ABT, vec_off: 5'h10, set_fdis: 1'b0, link_off: 4'd8};
      EXC_IRQ:  a = '{mode: MODE_IRQ, vec_off: 5'h18, set_fdis: 1'b0, link_off: 4'd4};
      EXC_FIQ:  a = '{mode: MODE_FIQ, vec_off: 5'h1C, set_fdis: 1'b1, link_off: 4'd4};
      default:  a = '{mode: MODE_SVC, vec_off: 5'h00, set_fdis: 1'b1, link_off: 4'd0};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/exc_qualify.sv
module exc_qualify
  import exc_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic               rst_req_i,
  input  logic               boot_pend_i,
  input  logic               holdoff_i,
  input  logic               und_req_i,
  input  logic               swi_req_i,
  input  logic               pabt_req_i,
  input  logic               pabt_exec_i,
  input  logic               dabt_req_i,
  input  logic               irq_i,
  input  logic               fiq_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [NUM_EXC-1:0] req_o
);

  logic in_fiq, irq_ok, fiq_ok, open_q;

  assign in_fiq = (status_i[MODE_W-1:0] == MODE_FIQ);
  assign irq_ok = irq_i & ~status_i[IRQ_DIS_BIT] & ~in_fiq;
  assign fiq_ok = fiq_i & ~status_i[FIQ_DIS_BIT];
  assign open_q = ~holdoff_i;

  always_comb begin
    req_o           = '0;
    req_o[EXC_RST]  = rst_req_i | boot_pend_i;
    req_o[EXC_DABT] = open_q & dabt_req_i;
    req_o[EXC_FIQ]  = open_q & fiq_ok;
    req_o[EXC_IRQ]  = open_q & irq_ok;
    req_o[EXC_PABT] = open_q & pabt_req_i & pabt_exec_i;
    req_o[EXC_UND]  = open_q & und_req_i;
    req_o[EXC_SWI]  = open_q & swi_req_i;
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  // lower index wins
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant_o[i] = req_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
  import exc_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                STAT_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [NUM_EXC-1:0] grant_i,
  input  logic               hivec_i,
  input  logic [STAT_W-1:0]  status_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic [ADDR_W-1:0]  vector_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic [STAT_W-1:0]  status_o,
  output logic [ADDR_W-1:0]  link_o
);

  exc_e      sel;
  exc_attr_t attr;
  logic [ADDR_W-1:0] base;

  always_comb begin
    sel = EXC_RST;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (grant_i[i]) sel = exc_e'(3'(i));
    end
  end

  assign attr     = exc_attr(sel);
  assign base     = hivec_i ? HI_BASE : '0;
  assign vector_o = base | ADDR_W'(attr.vec_off);
  assign mode_o   = attr.mode;

  always_comb begin
    if (sel == EXC_RST) begin
      status_o = '0;
      link_o   = '0;
    end else begin
      status_o = status_i;
      link_o   = pc_i + ADDR_W'(attr.link_off);
    end
    status_o[MODE_W-1:0]  = attr.mode;
    status_o[IRQ_DIS_BIT] = 1'b1;
    if (attr.set_fdis) status_o[FIQ_DIS_BIT] = 1'b1;
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                STAT_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              und_req_i,
  input  logic              swi_req_i,
  input  logic              pabt_req_i,
  input  logic              pabt_exec_i,
  input  logic              dabt_req_i,
  input  logic              irq_i,
  input  logic              fiq_i,
  input  logic              hivec_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] spsr_o,
  output logic [ADDR_W-1:0] link_o
);

  logic               boot_pend_q;
  logic [NUM_EXC-1:0] req, grant;
  logic               any_req;
  logic [ADDR_W-1:0]  vec_d, link_d;
  logic [MODE_W-1:0]  mode_d;
  logic [STAT_W-1:0]  stat_d;

  exc_qualify #(.STAT_W(STAT_W)) u_qual (
    .rst_req_i   (rst_req_i),
    .boot_pend_i (boot_pend_q),
    .holdoff_i   (take_o),
    .und_req_i   (und_req_i),
    .swi_req_i   (swi_req_i),
    .pabt_req_i  (pabt_req_i),
    .pabt_exec_i (pabt_exec_i),
    .dabt_req_i  (dabt_req_i),
    .irq_i       (irq_i),
    .fiq_i       (fiq_i),
    .status_i    (status_i),
    .req_o       (req)
  );

  exc_arbiter #(.N(NUM_EXC)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (any_req)
  );

  exc_entry_gen #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .HI_BASE(HI_BASE)) u_gen (
    .grant_i  (grant),
    .hivec_i  (hivec_i),
    .status_i (status_i),
    .pc_i     (pc_i),
    .vector_o (vec_d),
    .mode_o   (mode_d),
    .status_o (stat_d),
    .link_o   (link_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_pend_q <= 1'b1;
      take_o      <= 1'b0;
      vector_o    <= '0;
      mode_o      <= '0;
      status_o    <= '0;
      spsr_o      <= '0;
      link_o      <= '0;
    end else begin
      take_o <= any_req;
      if (any_req) begin
        boot_pend_q <= 1'b0;
        vector_o    <= vec_d;
        mode_o      <= mode_d;
        status_o    <= stat_d;
        spsr_o      <= status_i;
        link_o      <= link_d;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                STAT_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_req_i,
  input logic [STAT_W-1:0]  status_i,
  input logic               take_o,
  input logic [ADDR_W-1:0]  vector_o,
  input logic [MODE_W-1:0]  mode_o,
  input logic [STAT_W-1:0]  status_o,
  input logic [STAT_W-1:0]  spsr_o,
  input logic [NUM_EXC-1:0] grant
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(32'h1F);

  // R9
  take_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !rst_req_i |=> !take_o);

  // R9
  hold_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(vector_o));

  // R2
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (mode_o == MODE_FIQ || mode_o == MODE_IRQ || mode_o == MODE_SVC ||
                mode_o == MODE_ABT || mode_o == MODE_UND));

  // R3
  vec_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((vector_o & ~OFF_MASK) == '0 || (vector_o & ~OFF_MASK) == HI_BASE));

  // R4
  irq_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> status_o[IRQ_DIS_BIT]);

  // R4
  fiq_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && mode_o == MODE_FIQ |-> status_o[FIQ_DIS_BIT]);

  // R4
  spsr_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> spsr_o == $past(status_i));

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && mode_o == MODE_IRQ |->
      !$past(status_i[IRQ_DIS_BIT]) && $past(status_i[MODE_W-1:0]) != MODE_FIQ);

  // R7
  fiq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && mode_o == MODE_FIQ |-> !$past(status_i[FIQ_DIS_BIT]));

  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .HI_BASE(HI_BASE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_req_i (rst_req_i),
  .status_i  (status_i),
  .take_o    (take_o),
  .vector_o  (vector_o),
  .mode_o    (mode_o),
  .status_o  (status_o),
  .spsr_o    (spsr_o),
  .grant     (grant)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 0, und = 0, swi = 0, pabt = 0, pexec = 0, dabt = 0, irq = 0, fiq = 0, hv = 0;
  logic [31:0] st = 32'h10, pc = 32'h1000;
  logic        take;
  logic [31:0] vec, nst, spsr, link;
  logic [4:0]  mode;

  int errs = 0, checks = 0;
  logic [31:0] prev_vec = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .und_req_i(und), .swi_req_i(swi),
    .pabt_req_i(pabt), .pabt_exec_i(pexec), .dabt_req_i(dabt), .irq_i(irq), .fiq_i(fiq),
    .hivec_i(hv), .status_i(st), .pc_i(pc), .take_o(take), .vector_o(vec), .mode_o(mode),
    .status_o(nst), .spsr_o(spsr), .link_o(link)
  );

  // req order {rst, dabt, fiq, irq, pabt, und, swi}
  typedef struct packed {
    logic [6:0]  req;
    logic        pex;
    logic        hvc;
    logic [31:0] sti;
    logic        tk;
    logic [31:0] v;
    logic [4:0]  m;
    logic [31:0] s;
    logic [31:0] l;
  } row_t;

  localparam int NROW = 17;
  localparam row_t TBL [NROW] = '{
    '{7'b0000001, 1'b0, 1'b0, 32'h10,       1'b1, 32'h8,         5'h13, 32'h93,       32'h1004},
    '{7'b0000010, 1'b0, 1'b1, 32'h10,       1'b1, 32'hFFFF_0004, 5'h1B, 32'h9B,       32'h1004},
    '{7'b0000100, 1'b1, 1'b0, 32'h10,       1'b1, 32'hC,         5'h17, 32'h97,       32'h1004},
    '{7'b0000100, 1'b0, 1'b0, 32'h10,       1'b0, 32'h0,         5'h0,  32'h0,        32'h0},
    '{7'b0100000, 1'b0, 1'b0, 32'h10,       1'b1, 32'h10,        5'h17, 32'h97,       32'h1008},
    '{7'b0001000, 1'b0, 1'b0, 32'h10,       1'b1, 32'h18,        5'h12, 32'h92,       32'h1004},
    '{7'b0001000, 1'b0, 1'b0, 32'h90,       1'b0, 32'h0,         5'h0,  32'h0,        32'h0},
    '{7'b0010000, 1'b0, 1'b0, 32'h92,       1'b1, 32'h1C,        5'h11, 32'hD1,       32'h1004},
    '{7'b0010000, 1'b0, 1'b0, 32'h50,       1'b0, 32'h0,         5'h0,  32'h0,        32'h0},
    '{7'b0001000, 1'b0, 1'b0, 32'h11,       1'b0, 32'h0,         5'h0,  32'h0,        32'h0},
    '{7'b0011000, 1'b0, 1'b0, 32'h10,       1'b1, 32'h1C,        5'h11, 32'hD1,       32'h1004},
    '{7'b0110000, 1'b0, 1'b0, 32'h10,       1'b1, 32'h10,        5'h17, 32'h97,       32'h1008},
    '{7'b1111111, 1'b1, 1'b0, 32'h10,       1'b1, 32'h0,         5'h13, 32'hD3,       32'h0},
    '{7'b0001100, 1'b1, 1'b0, 32'h10,       1'b1, 32'h18,        5'h12, 32'h92,       32'h1004},
    '{7'b0000011, 1'b0, 1'b0, 32'h10,       1'b1, 32'h4,         5'h1B, 32'h9B,       32'h1004},
    '{7'b0001000, 1'b0, 1'b1, 32'h13,       1'b1, 32'hFFFF_0018, 5'h12, 32'h92,       32'h1004},
    '{7'b0000001, 1'b0, 1'b0, 32'hF000_0030, 1'b1, 32'h8,        5'h13, 32'hF000_00B3, 32'h1004}
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R2";  1: return "R3";  2: return "R8";  3: return "R8";
      4: return "R5";  5: return "R7";  6: return "R7";  7: return "R7";
      8: return "R7";  9: return "R7";  15: return "R3"; 16: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive(logic [6:0] r, logic pe, logic h, logic [31:0] s);
    {rst_req, dabt, fiq, irq, pabt, und, swi} = r;
    pexec = pe; hv = h; st = s;
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, take}, 32'd0);
    chk("R1", vec, 32'd0);
    chk("R1", nst, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 boot entry
    chk("R1", {31'd0, take}, 32'd1);
    chk("R1", vec, 32'h0);
    chk("R1", {27'd0, mode}, 32'h13);
    chk("R1", nst, 32'hD3);
    chk("R1", link, 32'h0);
    @(negedge clk);
    chk("R9", {31'd0, take}, 32'd0);

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i].req, TBL[i].pex, TBL[i].hvc, TBL[i].sti);
      @(negedge clk);
      chk(row_tag(i), {31'd0, take}, {31'd0, TBL[i].tk});
      if (TBL[i].tk) begin
        chk("R3", vec, TBL[i].v);
        chk("R2", {27'd0, mode}, {27'd0, TBL[i].m});
        chk("R4", nst, TBL[i].s);
        chk("R4", spsr, TBL[i].sti);
        chk("R5", link, TBL[i].l);
        prev_vec = TBL[i].v;
      end else begin
        chk("R9", vec, prev_vec);
      end
      drive(7'b0, 1'b0, 1'b0, 32'h10);
      @(negedge clk);
      chk("R9", {31'd0, take}, 32'd0);
    end

    // R10 held request: take, holdoff, take
    drive(7'b0000001, 1'b0, 1'b0, 32'h10);
    @(negedge clk);
    chk("R10", {31'd0, take}, 32'd1);
    @(negedge clk);
    chk("R10", {31'd0, take}, 32'd0);
    @(negedge clk);
    chk("R10", {31'd0, take}, 32'd1);
    // R10 reset request during take cycle is honoured
    drive(7'b1000000, 1'b0, 1'b0, 32'h10);
    @(negedge clk);
    chk("R10", {31'd0, take}, 32'd1);
    chk("R10", {27'd0, mode}, 32'h13);
    chk("R10", nst, 32'hD3);
    drive(7'b0, 1'b0, 1'b0, 32'h10);
    @(negedge clk);
    chk("R9", {31'd0, take}, 32'd0);
    chk("R9", vec, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule